// File: doc/BRIEF.md
# Multi-Port Blocking Stack Memory

This block is a last-in, first-out storage node that several neighbouring nodes share. Each neighbour owns one request port. It raises a request, says whether it wants to push or pop, and for a push it supplies a value. The request stays raised until the node acknowledges it. A push puts its value on top of the stack. A pop takes the top value away and returns it.

A push cannot be served while the stack is full, and a pop cannot be served while it is empty. Such a request simply waits without an acknowledge, and no data is lost or made up. A waiting request never stops another port from being served. At most one transfer completes per clock. When several ports are ready in the same cycle, a round-robin arbiter picks one of them.

A transfer completes on the rising clock edge where a port's request and its acknowledge are both high. For a pop, the returned value is valid on the shared read-data output during that cycle.

Top module: `stack_mem_node`

## Requirements
- R1: After reset the stack is empty and no acknowledge is high. A pop request made straight after reset stays unacknowledged.
- R2: A push makes its value the new top of the stack. The next pop returns that value.
- R3: Values come back in reverse order of their pushes, for any number of entries up to the capacity.
- R4: A push made while the stack holds DEPTH entries is not acknowledged. It completes in the cycle after a pop frees an entry.
- R5: A pop made while the stack is empty is not acknowledged. It completes in the cycle after a push supplies a value, and it returns that value.
- R6: At most one port is acknowledged in any cycle.
- R7: Ports are served round-robin. When several ports keep requesting, a port that was just served is not served again while another port that was requesting is still waiting. Four simultaneous pushes are therefore acknowledged in four consecutive cycles, in rising cyclic port order.
- R8: When a push and a pop are both pending on a stack that is neither full nor empty, they are served in two separate cycles. The result is the same as running the two operations one after the other.
- R9: Values are 11-bit two's complement numbers and are returned unchanged. This includes -999, 999, 0 and -1. Capacity is set by the DEPTH parameter, which defaults to 15.
- R10: Any port may push or pop. A value pushed through one port can be popped through any other port.
- R11: A push that is stalled on a full stack does not stop a pop on another port from being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl_valid | input | NP | Request held high per port until acknowledged |
| cl_write | input | NP | Operation per port: 1 means push, 0 means pop |
| cl_wdata | input | NP*VAL_W | Push values; port i uses bits [i*VAL_W +: VAL_W] |
| cl_ack | output | NP | Acknowledge; the transfer completes on the edge where request and acknowledge are both high |
| cl_rdata | output | VAL_W | Popped value, valid while a pop request is acknowledged |

## Verification
The bench sweeps every pairing of push port and pop port. Each pairing fills the stack to capacity and then drains it, so a pointer that is off by one would return the wrong value or overwrite the bottom entry. Two boundary cases are tested with a second port arriving later to release the stall: a pop on an empty stack and a push on a full stack. A design that acknowledged these requests early would return stale data or lose a value. A design that let a stalled port block the others would hang. When push and pop are pending together, the bench accepts either service order but checks that the contents stay consistent, which catches a merged or dropped operation. Four simultaneous pushes must be granted on consecutive cycles in cyclic port order, which catches fixed-priority starvation and double grants.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int unsigned STK_NP_DEF    = 4;
    localparam int unsigned STK_DEPTH_DEF = 15;
    localparam int unsigned STK_VAL_W_DEF = 11;

    typedef enum logic {
        OP_POP  = 1'b0,
        OP_PUSH = 1'b1
    } stk_op_e;
endpackage

// File: rtl/stk_rr_arb.sv
module stk_rr_arb #(
    parameter int unsigned NP = 4,
    localparam int unsigned IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] grant,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_valid
);
    typedef struct packed {
        logic [IW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        int cand;
        st_d      = st_q;
        grant     = '0;
        gnt_idx   = '0;
        gnt_valid = 1'b0;
        cand      = 0;
        // search starts one past the last winner and wraps around
        for (int k = 1; k <= int'(NP); k++) begin
            cand = (int'(st_q.last) + k) % int'(NP);
            if (!gnt_valid && req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(cand);
            end
        end
        if (gnt_valid) begin
            grant[gnt_idx] = 1'b1;
            st_d.last      = gnt_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.last <= IW'(NP - 1);
        else        st_q      <= st_d;
    end

    // R6: a single winner per cycle
    p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: another port still waiting means the last winner does not win again
    p_rr_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> (((req & ~$past(grant) & $past(req)) == '0) || (grant != $past(grant))));
endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int unsigned DEPTH = 15,
    parameter int unsigned W     = 11,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[AW'(st_q.cnt)] = wdata;
            st_d.cnt                = st_q.cnt + CW'(1);
        end else if (pop) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_comb begin
        full  = (st_q.cnt == CW'(DEPTH));
        empty = (st_q.cnt == '0);
        rdata = empty ? '0 : st_q.mem[AW'(st_q.cnt - CW'(1))];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_single_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (rdata == $past(wdata)));
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/stack_mem_node.sv
module stack_mem_node
    import stk_pkg::*;
#(
    parameter int unsigned NP    = STK_NP_DEF,
    parameter int unsigned DEPTH = STK_DEPTH_DEF,
    parameter int unsigned VAL_W = STK_VAL_W_DEF,
    localparam int unsigned IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NP-1:0]       cl_valid,
    input  logic [NP-1:0]       cl_write,
    input  logic [NP*VAL_W-1:0] cl_wdata,
    output logic [NP-1:0]       cl_ack,
    output logic [VAL_W-1:0]    cl_rdata
);
    logic [NP-1:0]    ready;
    logic [NP-1:0]    grant;
    logic [IW-1:0]    gnt_idx;
    logic             gnt_valid;
    logic             st_full, st_empty;
    logic             do_push, do_pop;
    logic [VAL_W-1:0] push_val;
    stk_op_e          win_op;

    // a port may compete only when its operation can complete now
    always_comb begin
        for (int i = 0; i < int'(NP); i++) begin
            ready[i] = cl_valid[i] && (cl_write[i] ? !st_full : !st_empty);
        end
    end

    stk_rr_arb #(.NP(NP)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ready),
        .grant     (grant),
        .gnt_idx   (gnt_idx),
        .gnt_valid (gnt_valid)
    );

    always_comb begin
        win_op   = stk_op_e'(cl_write[gnt_idx]);
        do_push  = gnt_valid && (win_op == OP_PUSH);
        do_pop   = gnt_valid && (win_op == OP_POP);
        push_val = cl_wdata[gnt_idx*VAL_W +: VAL_W];
    end

    stk_store #(.DEPTH(DEPTH), .W(VAL_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .pop   (do_pop),
        .wdata (push_val),
        .rdata (cl_rdata),
        .full  (st_full),
        .empty (st_empty)
    );

    assign cl_ack = grant;

    for (genvar g = 0; g < int'(NP); g++) begin : g_port_chk
        p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cl_valid[g] && cl_write[g] && st_full) |-> !cl_ack[g]);
        p_empty_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cl_valid[g] && !cl_write[g] && st_empty) |-> !cl_ack[g]);
        p_ack_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cl_ack[g] |-> cl_valid[g]);
    end
endmodule

// File: tb/stack_mem_node_tb.sv
`timescale 1ns/1ps
module stack_mem_node_tb;
    localparam int NP = 4;
    localparam int DEPTH = 4;
    localparam int W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] v = '0, wr = '0;
    logic [W-1:0] dd [NP];
    logic [NP-1:0] ack;
    logic [W-1:0] rdata;
    int cyc = 0, n_run = 0, n_fail = 0, mon_err = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stack_mem_node #(.NP(NP), .DEPTH(DEPTH), .VAL_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cl_valid(v), .cl_write(wr),
        .cl_wdata({dd[3], dd[2], dd[1], dd[0]}), .cl_ack(ack), .cl_rdata(rdata));

    // R6 monitor
    always @(negedge clk) if (rst_n && $countones(ack) > 1) mon_err++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic xfer(input int p, input bit w, input logic [W-1:0] d,
                        output logic [W-1:0] r, output int at);
        @(negedge clk); v[p] = 1'b1; wr[p] = w; dd[p] = d;
        r = '0; at = -1;
        for (int n = 0; n < 300; n++) begin
            #1;
            if (ack[p]) begin
                r = rdata; at = cyc;
                @(negedge clk); v[p] = 1'b0;
                return;
            end
            @(negedge clk);
        end
        v[p] = 1'b0;
    endtask

    task automatic hold_nack(input int p, input bit w, input logic [W-1:0] d, input string tag);
        int hits = 0;
        @(negedge clk); v[p] = 1'b1; wr[p] = w; dd[p] = d;
        for (int n = 0; n < 4; n++) begin
            #1; if (ack[p]) hits++;
            @(negedge clk);
        end
        v[p] = 1'b0;
        check(hits == 0, tag, hits, 0);
    endtask

    task automatic push_chk(input int p, input int val, input string tag);
        logic [W-1:0] r; int at;
        xfer(p, 1'b1, W'(val), r, at);
        check(at >= 0, tag, at, 0);
    endtask

    task automatic pop_chk(input int p, input int exp, input string tag);
        logic [W-1:0] r; int at;
        xfer(p, 1'b0, '0, r, at);
        check(at >= 0 && $signed(r) == exp, tag, $signed(r), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int model [DEPTH];
        logic [W-1:0] ra, rb;
        int aa, ab, g;
        int at4 [NP];
        logic [W-1:0] r4 [NP];
        for (int i = 0; i < NP; i++) dd[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check(ack == '0, "R1 idle ack after reset", ack, 0);
        hold_nack(0, 1'b0, '0, "R1 R5 pop on empty after reset");

        // R3 R10 R4 R5: sweep of push/pop port pairings, full fill and drain
        for (int pp = 0; pp < NP; pp++) begin
            for (int qp = 0; qp < NP; qp++) begin
                for (int k = 0; k < DEPTH; k++) begin
                    model[k] = (((pp * 4 + qp) * 97 + k * 211) % 1999) - 999;
                    push_chk((pp + k) % NP, model[k], "R10 push accepted");
                end
                hold_nack(qp, 1'b1, 11'd5, "R4 push on full stalls");
                for (int k = 0; k < DEPTH; k++)
                    pop_chk((qp + k) % NP, model[DEPTH-1-k], "R3 R10 LIFO order");
                hold_nack(pp, 1'b0, '0, "R5 pop on drained stack stalls");
            end
        end

        // R9 extremes
        push_chk(0, -999, "R9 push -999");
        push_chk(1, 999, "R9 push 999");
        push_chk(2, 0, "R9 push 0");
        push_chk(3, -1, "R9 push -1");
        pop_chk(0, -1, "R9 value -1");
        pop_chk(1, 0, "R9 value 0");
        pop_chk(2, 999, "R9 value 999");
        pop_chk(3, -999, "R9 value -999");

        // R5 R2: stalled pop released by a later push
        fork
            xfer(0, 1'b0, '0, ra, aa);
            begin repeat (5) @(negedge clk); xfer(2, 1'b1, 11'd321, rb, ab); end
        join
        check($signed(ra) == 321, "R5 R2 released pop value", $signed(ra), 321);
        check(aa == ab + 1, "R5 pop completes cycle after push", aa, ab + 1);

        // R11 R4: stalled push does not block a pop, then completes
        for (int k = 0; k < DEPTH; k++) push_chk(k % NP, 10 + k, "R11 fill");
        fork
            xfer(1, 1'b1, 11'd77, ra, aa);
            begin repeat (3) @(negedge clk); xfer(3, 1'b0, '0, rb, ab); end
        join
        check($signed(rb) == 10 + DEPTH - 1, "R11 pop served past stalled push", $signed(rb), 10 + DEPTH - 1);
        check(aa == ab + 1, "R4 push completes cycle after pop", aa, ab + 1);
        pop_chk(0, 77, "R4 released push on top");
        for (int k = DEPTH - 2; k >= 0; k--) pop_chk(2, 10 + k, "R11 remaining order");

        // R8: concurrent push and pop on a partially filled stack
        push_chk(0, 5, "R8 prefill");
        push_chk(0, 6, "R8 prefill");
        fork
            xfer(0, 1'b1, 11'd40, ra, aa);
            xfer(1, 1'b0, '0, rb, ab);
        join
        check(aa >= 0 && ab >= 0 && aa != ab, "R8 separate cycles", aa, ab + 1);
        if (aa < ab) begin
            check($signed(rb) == 40, "R8 pop after push", $signed(rb), 40);
            pop_chk(2, 6, "R8 remaining top");
        end else begin
            check($signed(rb) == 6, "R8 pop before push", $signed(rb), 6);
            pop_chk(2, 40, "R8 remaining top");
        end
        pop_chk(3, 5, "R8 remaining bottom");

        // R7 R6: four simultaneous pushes
        fork
            xfer(0, 1'b1, 11'd100, r4[0], at4[0]);
            xfer(1, 1'b1, 11'd101, r4[1], at4[1]);
            xfer(2, 1'b1, 11'd102, r4[2], at4[2]);
            xfer(3, 1'b1, 11'd103, r4[3], at4[3]);
        join
        g = 0;
        for (int i = 1; i < NP; i++) if (at4[i] < at4[g]) g = i;
        for (int k = 1; k < NP; k++)
            check(at4[(g + k) % NP] == at4[g] + k, "R7 cyclic consecutive grants",
                  at4[(g + k) % NP], at4[g] + k);
        for (int k = 0; k < NP; k++)
            pop_chk(k, 100 + (g + NP - 1 - k) % NP, "R7 grant order matches data");

        check(mon_err == 0, "R6 single ack per cycle", mon_err, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule